// File: doc/BRIEF.md
# SPI Transmit Buffer and Mode-Fault Controller

This block is a byte-wide SPI engine that can run as bus master or as slave. Software writes a byte into a one-deep transmit holding buffer. The engine moves the byte into its own shift register as soon as it can start a transfer, so the next byte can be written while the current one is still shifting out. A transmit-empty status flag tells software when the buffer can be refilled. That flag can also raise an interrupt request, gated by an enable bit in the control word.

The slave-select pin has two roles. When the block is an enabled master with mode-fault detection turned on, a low level on the pin is taken as a sign that a second master is driving the bus. The block then records a sticky mode-fault flag, abandons the transfer and leaves master mode. When detection is off, the master ignores the pin and releases it for general-purpose use. As a slave, the pin always frames the transfer. In master mode, two rate bits choose one of four serial clock rates.

Control word layout (`ctrl_in` / `ctrl_out`): bit 0 enable, bit 1 master, bit 2 mode-fault enable, bit 3 transmit-empty interrupt enable, bits 5:4 rate code.

Top module: `spi_txb_core`

## Requirements
- R1: After reset, `tx_empty` is 1, `mode_fault` is 0, `ctrl_out` is 0 (rate code 00) and `sck_o` is low.
- R2: A data write drives `tx_empty` low from the next cycle. `tx_empty` returns high in the cycle after the byte moves from the buffer into the shift register.
- R3: `irq` is high exactly when `tx_empty` is 1 and control bit 3 is 1.
- R4: A master transfer is 8 bits, MSB first. `sdo` updates on each rising `sck_o` edge and `sdi` is sampled on each falling edge. The received byte appears on `rx_data` with a one-cycle `xfer_done` pulse after the eighth falling edge.
- R5: In master mode, each `sck_o` phase lasts 1, 4, 16 or 64 clock cycles for rate codes 00, 01, 10 and 11. This is a serial clock of the module clock divided by 2, 8, 32 or 128.
- R6: If the buffer holds a byte when a transfer ends, that byte is loaded in the same cycle and the next transfer follows with no idle gap.
- R7: As an enabled master with mode-fault enable 1, a low `ss_i` sets `mode_fault` three clock edges after the pin falls (two synchroniser stages plus the flag). In the same edge, control bit 1 (master) is cleared and any transfer in progress is dropped, with `sck_o` returned low.
- R8: As an enabled master with mode-fault enable 0, `ss_i` is ignored and `ss_gpio` is 1. `ss_gpio` is also 1 while the block is disabled, and 0 in every other case.
- R9: `mode_fault` stays set when mode-fault enable is cleared. It is cleared only by a control write that follows a status read (`stat_rd`) made while the flag was set.
- R10: As an enabled slave, a transfer runs while `ss_i` is low and is clocked by the falling and rising edges of `sck_i` after synchronisation. The rate bits have no effect, and `sck_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the transmit buffer |
| data_in | input | 8 | Byte to transmit |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_in | input | 6 | Control word to write |
| stat_rd | input | 1 | Status read strobe (arms mode-fault clearing) |
| tx_empty | output | 1 | Transmit buffer empty flag |
| mode_fault | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Transmit-empty interrupt request |
| ctrl_out | output | 6 | Control word readback |
| rx_data | output | 8 | Last received byte |
| xfer_done | output | 1 | One-cycle pulse when a byte completes |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_i | input | 1 | Slave-select pin, active low |
| ss_gpio | output | 1 | 1 when the slave-select pin is free for general-purpose use |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
A wrong buffer-occupancy state shows at `tx_empty` and `irq` on the very next cycle. The same error then shows a few cycles later as a missing or doubled transfer on `sck_o`. A miscounted divider or bit counter shifts the next `sck_o` edge by at least one cycle, so the per-cycle comparison against the bench model catches it at the first bad edge. A mode-fault or role error appears in `mode_fault` and `ctrl_out` exactly three edges after the `ss_i` change. Sticky-flag faults stay hidden until the specific read-then-write clearing sequence is driven.

// File: rtl/spi_txb_pkg.sv
package spi_txb_pkg;

  localparam int RATE_W = 2;
  localparam int CNT_W  = 7;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              txe_ie;
    logic              fault_en;
    logic              master;
    logic              en;
  } spi_ctrl_t;

  localparam int CTRL_W = $bits(spi_ctrl_t);

  // clock cycles per serial clock phase: 4 ** code
  function automatic logic [CNT_W-1:0] phase_len(input logic [RATE_W-1:0] code);
    phase_len = CNT_W'(1) << {code, 1'b0};
  endfunction

endpackage

// File: rtl/spi_txb_sync.sv
module spi_txb_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spi_txb_buffer.sv
module spi_txb_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] buf_q,
  output logic              full_q,
  output logic              tx_empty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      buf_q  <= wr_data;
      full_q <= 1'b1;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  assign tx_empty = ~full_q;

  // R2
  empty_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> tx_empty);

  // R2
  full_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);

endmodule

// File: rtl/spi_txb_ctl.sv
module spi_txb_ctl
  import spi_txb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  spi_ctrl_t ctrl_wdata,
  input  logic      stat_rd,
  input  logic      fault_evt,
  output spi_ctrl_t ctrl_q,
  output logic      fault_q
);
  logic arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fault_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      if (ctrl_wr)   ctrl_q <= ctrl_wdata;
      if (fault_evt) ctrl_q.master <= 1'b0;

      if (fault_evt)             fault_q <= 1'b1;
      else if (ctrl_wr && arm_q) fault_q <= 1'b0;

      if (stat_rd && fault_q) arm_q <= 1'b1;
      else if (ctrl_wr)       arm_q <= 1'b0;
    end
  end

  // R7
  fault_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (fault_q && !ctrl_q.master));

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !(ctrl_wr && arm_q)) |=> fault_q);

  // R9
  fault_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(ctrl_q.fault_en));

endmodule

// File: rtl/spi_txb_shifter.sv
module spi_txb_shifter
  import spi_txb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_m,
  input  logic              run_s,
  input  logic              ss_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [RATE_W-1:0] rate,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_full,
  input  logic              sdi,
  output logic              load,
  output logic              sck_o,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_data,
  output logic              done
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, is_m_q, sck_q;
  logic [BIT_W-1:0]  bits_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  // named internal events
  logic abort, start, rate_run, tick, step_lead, step_trail, last;
  logic [DATA_W-1:0] shifted;
  logic [CNT_W-1:0]  phase;

  assign phase    = phase_len(rate);
  assign abort    = busy_q & ((is_m_q & ~run_m) | (~is_m_q & (~run_s | ~ss_act)));
  assign start    = ~busy_q & buf_full & (run_m | (run_s & ss_act));
  assign rate_run = busy_q & is_m_q & ~abort;
  assign tick     = rate_run & (cnt_q >= (phase - CNT_W'(1)));

  assign step_lead  = busy_q & ~abort & (is_m_q ? (tick & ~sck_q) : sck_rise);
  assign step_trail = busy_q & ~abort & (is_m_q ? (tick &  sck_q) : sck_fall);
  assign shifted    = {sh_q[DATA_W-2:0], sdi};
  assign last       = step_trail & (bits_q == LAST_BIT);
  assign load       = start | (last & buf_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!rate_run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_m_q  <= 1'b0;
      sck_q   <= 1'b0;
      bits_q  <= '0;
      sh_q    <= '0;
      sdo     <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        bits_q <= '0;
      end else begin
        if (start) begin
          busy_q <= 1'b1;
          is_m_q <= run_m;
          bits_q <= '0;
          sck_q  <= 1'b0;
        end
        if (tick) sck_q <= ~sck_q;
        if (step_lead) sdo <= sh_q[DATA_W-1];
        if (step_trail) begin
          sh_q   <= shifted;
          bits_q <= last ? '0 : bits_q + BIT_W'(1);
        end
        if (last) begin
          rx_data <= shifted;
          if (!buf_full) busy_q <= 1'b0;
        end
        if (load) sh_q <= buf_data;
      end
    end
  end

  assign sck_o = sck_q;

  // R4
  sck_only_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> busy_q);

  // R5
  sck_holds_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_m_q && !tick && !abort) |=> $stable(sck_q));

  // R6
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && buf_full) |=> busy_q);

  // R10
  slave_no_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !is_m_q) |-> !sck_q);

endmodule

// File: rtl/spi_txb_core.sv
module spi_txb_core
  import spi_txb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              stat_rd,
  output logic              tx_empty,
  output logic              mode_fault,
  output logic              irq,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              xfer_done,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_i,
  output logic              ss_gpio,
  output logic              sdo,
  input  logic              sdi
);
  spi_ctrl_t         ctrl_q;
  logic              ss_s, sck_s, sck_d;
  logic              fault_evt, run_m, run_s, load, full_q;
  logic [DATA_W-1:0] buf_q;

  spi_txb_sync #(.RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_s));

  spi_txb_sync #(.RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign fault_evt = ctrl_q.en & ctrl_q.master & ctrl_q.fault_en & ~ss_s;
  assign run_m     = ctrl_q.en & ctrl_q.master & ~fault_evt;
  assign run_s     = ctrl_q.en & ~ctrl_q.master;

  spi_txb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(spi_ctrl_t'(ctrl_in)),
    .stat_rd(stat_rd), .fault_evt(fault_evt),
    .ctrl_q(ctrl_q), .fault_q(mode_fault));

  spi_txb_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_wr), .wr_data(data_in), .load(load),
    .buf_q(buf_q), .full_q(full_q), .tx_empty(tx_empty));

  spi_txb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .run_m(run_m), .run_s(run_s), .ss_act(~ss_s),
    .sck_rise(sck_s & ~sck_d), .sck_fall(~sck_s & sck_d),
    .rate(ctrl_q.rate), .buf_data(buf_q), .buf_full(full_q),
    .sdi(sdi), .load(load), .sck_o(sck_o), .sdo(sdo),
    .rx_data(rx_data), .done(xfer_done));

  assign irq      = tx_empty & ctrl_q.txe_ie;
  assign ctrl_out = ctrl_q;
  assign ss_gpio  = ~ctrl_q.en | (ctrl_q.master & ~ctrl_q.fault_en);

  // R3
  irq_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_empty);

  // R8
  gpio_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_gpio && !mode_fault) |=> !mode_fault);

endmodule

// File: tb/spi_txb_core_tb.sv
module spi_txb_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_in = 6'h00;
  logic       stat_rd = 1'b0;
  logic       sck_i = 1'b0;
  logic       ss_i = 1'b1;
  logic       sdi_drv = 1'b0;
  logic       loop_en = 1'b0;
  logic       tx_empty, mode_fault, irq, xfer_done, sck_o, ss_gpio, sdo, sdi;
  logic [5:0] ctrl_out;
  logic [7:0] rx_data;

  assign sdi = loop_en ? sdo : sdi_drv;

  always #2 clk = ~clk;

  spi_txb_core u_dut (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in), .stat_rd(stat_rd),
    .tx_empty(tx_empty), .mode_fault(mode_fault), .irq(irq),
    .ctrl_out(ctrl_out), .rx_data(rx_data), .xfer_done(xfer_done),
    .sck_o(sck_o), .sck_i(sck_i), .ss_i(ss_i), .ss_gpio(ss_gpio),
    .sdo(sdo), .sdi(sdi));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int hi_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // ---------------- behavioural reference model ----------------
  int m_full, m_buf, m_busy, m_ism, m_sck, m_cnt, m_bits, m_sh, m_sdo, m_rx, m_done;
  int m_ctrl, m_fault, m_arm;
  int m_ss_m, m_ss_s, m_ck_m, m_ck_s, m_ck_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_buf = 0; m_busy = 0; m_ism = 0; m_sck = 0; m_cnt = 0;
      m_bits = 0; m_sh = 0; m_sdo = 0; m_rx = 0; m_done = 0;
      m_ctrl = 0; m_fault = 0; m_arm = 0;
      m_ss_m = 1; m_ss_s = 1; m_ck_m = 0; m_ck_s = 0; m_ck_d = 0;
    end else begin
      int en, ms, fen, fev, runm, runs, phase, lead, trail, ldd, nv, nc;
      en = m_ctrl & 1; ms = (m_ctrl >> 1) & 1; fen = (m_ctrl >> 2) & 1;
      fev  = en && ms && fen && (m_ss_s == 0);
      runm = en && ms && !fev;
      runs = en && !ms;
      phase = 1;
      repeat ((m_ctrl >> 4) & 3) phase = phase * 4;
      lead = 0; trail = 0; ldd = 0; m_done = 0;
      if (m_busy && ((m_ism && !runm) || (!m_ism && (!runs || m_ss_s)))) begin
        m_busy = 0; m_sck = 0; m_cnt = 0; m_bits = 0;
      end else if (!m_busy) begin
        m_cnt = 0;
        if (m_full && (runm || (runs && !m_ss_s))) begin
          m_busy = 1; m_ism = runm; m_bits = 0; m_sck = 0; m_sh = m_buf; ldd = 1;
        end
      end else begin
        if (m_ism) begin
          if (m_cnt >= phase - 1) begin
            m_cnt = 0; lead = !m_sck; trail = m_sck; m_sck = !m_sck;
          end else m_cnt++;
        end else begin
          lead  = m_ck_s && !m_ck_d;
          trail = !m_ck_s && m_ck_d;
        end
        if (lead) m_sdo = (m_sh >> 7) & 1;
        if (trail) begin
          nv = ((m_sh << 1) | int'(sdi)) & 8'hFF;
          m_bits++;
          if (m_bits == 8) begin
            m_bits = 0; m_done = 1; m_rx = nv;
            if (m_full) begin m_sh = m_buf; ldd = 1; end
            else begin m_sh = nv; m_busy = 0; end
          end else m_sh = nv;
        end
      end
      if (data_wr) begin m_full = 1; m_buf = int'(data_in); end
      else if (ldd) m_full = 0;
      nc = m_ctrl;
      if (ctrl_wr) nc = int'(ctrl_in);
      if (fev) nc = nc & ~2;
      if (fev) m_fault = 1;
      else if (ctrl_wr && m_arm) m_fault = 0;
      if (stat_rd && m_fault) m_arm = 1;
      else if (ctrl_wr) m_arm = 0;
      m_ctrl = nc;
      m_ss_s = m_ss_m; m_ss_m = int'(ss_i);
      m_ck_d = m_ck_s; m_ck_s = m_ck_m; m_ck_m = int'(sck_i);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (sck_o) hi_cnt++;
    if (rst_n) begin
      chk(int'(tx_empty) == (m_full ? 0 : 1), "R2 tx_empty", int'(tx_empty), m_full ? 0 : 1);
      chk(int'(irq) == ((!m_full && ((m_ctrl >> 3) & 1)) ? 1 : 0), "R3 irq", int'(irq),
          (!m_full && ((m_ctrl >> 3) & 1)) ? 1 : 0);
      chk(int'(mode_fault) == m_fault, "R7 mode_fault", int'(mode_fault), m_fault);
      chk(int'(ctrl_out) == m_ctrl, "R9 ctrl_out", int'(ctrl_out), m_ctrl);
      chk(int'(sck_o) == m_sck, "R5 sck_o", int'(sck_o), m_sck);
      chk(int'(sdo) == m_sdo, "R4 sdo", int'(sdo), m_sdo);
      chk(int'(rx_data) == m_rx, "R4 rx_data", int'(rx_data), m_rx);
      chk(int'(xfer_done) == m_done, "R6 xfer_done", int'(xfer_done), m_done);
      chk(int'(ss_gpio) == ((!(m_ctrl & 1) || ((m_ctrl & 6) == 2)) ? 1 : 0), "R8 ss_gpio",
          int'(ss_gpio), (!(m_ctrl & 1) || ((m_ctrl & 6) == 2)) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; data_in = b;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [5:0] c);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_in = c;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (xfer_done) begin at = cyc; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int t1, t2;
    logic [7:0] got;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
    chk(mode_fault == 1'b0, "R1 mode_fault after reset", int'(mode_fault), 0);
    chk(ctrl_out == 6'h00, "R1 ctrl after reset", int'(ctrl_out), 0);
    chk(sck_o == 1'b0, "R1 sck idle", int'(sck_o), 0);

    // R4 / R5: master loopback at rate code 10
    loop_en = 1'b1;
    wr_ctrl(6'h23);
    hi_cnt = 0;
    wr_byte(8'hA5);
    wait_done(5000, t1);
    chk(t1 >= 0, "R4 transfer finished", t1, 1);
    chk(rx_data == 8'hA5, "R4 loopback byte", int'(rx_data), 8'hA5);
    chk(hi_cnt == 128, "R5 sck high cycles code 10", hi_cnt, 128);

    // R5 code 11
    wr_ctrl(6'h33);
    hi_cnt = 0;
    wr_byte(8'h0F);
    wait_done(5000, t1);
    chk(hi_cnt == 512, "R5 sck high cycles code 11", hi_cnt, 512);
    chk(rx_data == 8'h0F, "R4 loopback byte 2", int'(rx_data), 8'h0F);

    // R6 back-to-back at code 00
    wr_ctrl(6'h03);
    wr_byte(8'h11);
    wr_byte(8'h22);
    wait_done(500, t1);
    chk(rx_data == 8'h11, "R6 first byte", int'(rx_data), 8'h11);
    wait_done(500, t2);
    chk(rx_data == 8'h22, "R6 second byte", int'(rx_data), 8'h22);
    chk(t2 - t1 == 16, "R6 no idle gap", t2 - t1, 16);
    idle(4);

    // R7 mode fault during a transfer
    wr_ctrl(6'h37);
    wr_byte(8'hC3);
    idle(200);
    ss_i = 1'b0;
    idle(6);
    chk(mode_fault == 1'b1, "R7 fault set", int'(mode_fault), 1);
    chk(ctrl_out == 6'h35, "R7 master cleared", int'(ctrl_out), 6'h35);
    chk(sck_o == 1'b0, "R7 sck dropped", int'(sck_o), 0);
    ss_i = 1'b1;
    idle(4);

    // R9 sticky flag and its clearing sequence
    wr_ctrl(6'h31);
    idle(2);
    chk(mode_fault == 1'b1, "R9 fault kept after enable cleared", int'(mode_fault), 1);
    rd_stat();
    wr_ctrl(6'h01);
    idle(1);
    chk(mode_fault == 1'b0, "R9 fault cleared by read then write", int'(mode_fault), 0);

    // R8 master with detection off ignores SS
    wr_ctrl(6'h03);
    ss_i = 1'b0;
    wr_byte(8'h5A);
    wait_done(500, t1);
    chk(rx_data == 8'h5A, "R8 transfer with ss low", int'(rx_data), 8'h5A);
    chk(mode_fault == 1'b0, "R8 no fault", int'(mode_fault), 0);
    chk(ss_gpio == 1'b1, "R8 ss released", int'(ss_gpio), 1);
    ss_i = 1'b1;
    idle(4);

    // R3 interrupt gating
    wr_ctrl(6'h08);
    idle(1);
    chk(irq == 1'b1, "R3 irq when empty and enabled", int'(irq), 1);
    wr_byte(8'h96);
    idle(1);
    chk(irq == 1'b0, "R3 irq low when full", int'(irq), 0);

    // R10 slave transfer, rate bits set but unused
    loop_en = 1'b0;
    wr_ctrl(6'h31);
    idle(2);
    chk(ss_gpio == 1'b0, "R10 ss is SPI pin", int'(ss_gpio), 0);
    ss_i = 1'b0;
    idle(5);
    chk(tx_empty == 1'b1, "R10 byte loaded", int'(tx_empty), 1);
    got = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      sdi_drv = 1'(8'h3C >> b);
      idle(4);
      sck_i = 1'b1;
      idle(6);
      got = {got[6:0], sdo};
      sck_i = 1'b0;
      idle(6);
    end
    chk(rx_data == 8'h3C, "R10 slave received", int'(rx_data), 8'h3C);
    chk(got == 8'h96, "R10 slave sent", int'(got), 8'h96);
    chk(sck_o == 1'b0, "R10 sck_o quiet", int'(sck_o), 0);
    ss_i = 1'b1;
    idle(6);

    summary();
    $finish;
  end
endmodule